// File: doc/BRIEF.md
# Signed 32-bit Multicycle Divider with LO/HI Results

This block divides two signed 32-bit integers for a 64-bit register processor. A one-cycle start pulse hands it two 64-bit operands. Only the low 32 bits of each operand are used, read as two's-complement values. The result is a truncated quotient in LO and a remainder in HI. Each is cut to 32 bits and then sign-extended to 64 bits. When the result is ready, a one-cycle done pulse is raised.

The divisor may be zero. The block does not trap in that case. It produces a fixed result: HI gets the sign-extended dividend, and LO gets minus one or plus one depending on the sign of the dividend.

Internally the block works on magnitudes and corrects the signs at the end. It uses a radix-2 restoring loop with one quotient bit per clock. A three-state controller sequences the work:

- S_IDLE moves to S_ITER on an accepted start, which loads the operands.
- S_ITER stays in place for 32 steps, then moves to S_FIX after the last step.
- S_FIX returns to S_IDLE. On that edge the corrected results are written to LO and HI and done is raised.

Top module: `lohi_divider`

## Requirements
- R1: Operand bits 63..32 have no effect on any result. The dividend is op_a_i[31:0] and the divisor is op_b_i[31:0], both read as signed 32-bit values.
- R2: When the divisor is zero, HI equals the 32-bit dividend sign-extended to 64 bits.
- R3: When the divisor is zero and the dividend is zero or positive, LO is all ones (minus one).
- R4: When the divisor is zero and the dividend is negative, LO is one.
- R5: For a nonzero divisor, LO is the quotient rounded toward zero and HI is the remainder. The remainder is zero or has the sign of the dividend, and its magnitude is below that of the divisor.
- R6: LO and HI are each a 32-bit value sign-extended to 64 bits: bits 63..32 all equal bit 31.
- R7: The most negative value divided by minus one gives LO = 0xFFFFFFFF80000000 and HI = 0.
- R8: done_o is high for exactly one cycle. It follows the 33rd rising edge after the edge that samples an accepted start, and LO/HI hold the new result in that same cycle. busy_o is high from the accepting edge until done_o rises.
- R9: A start pulse that arrives while busy_o is high is ignored. The running result and its timing are unchanged, and no extra done pulse appears.
- R10: After reset, done_o and busy_o are low and LO and HI are zero. LO and HI change only in a cycle where done_o is high, and keep their value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_a_i | input | 64 | Dividend operand (low 32 bits used) |
| op_b_i | input | 64 | Divisor operand (low 32 bits used) |
| done_o | output | 1 | One-cycle pulse when a result is written |
| busy_o | output | 1 | High while a division is in progress |
| lo_o | output | 64 | Sign-extended quotient, or the zero-divisor LO value |
| hi_o | output | 64 | Sign-extended remainder, or the dividend on zero divisor |

## Verification
The directed cases cover each sign pairing of dividend and divisor. They show whether rounding goes toward zero and whether the remainder takes the dividend's sign, not the divisor's.

Zero divisors with a positive, a zero and a negative dividend separate the two LO rules for the zero-divisor case from the normal path. The most-negative-by-minus-one case and the most-negative-by-one case exercise the wrapped quotient at the 32-bit boundary. Operands with junk in their upper halves show that only the low words are used.

Seeded random operands are drawn both at full width and with small divisors, so that many quotient bits are set. A start pulse raised in the middle of a division, and operand changes while idle, check that a result is only replaced by an accepted start.

// File: rtl/lohi_div_pkg.sv
package lohi_div_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ITER = 2'd1,
        S_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/lohi_div_fsm.sv
module lohi_div_fsm
    import lohi_div_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic load_o,
    output logic step_o,
    output logic fix_o
);
    localparam int CW = $clog2(DW);

    div_state_e      state_q, state_d;
    logic [CW-1:0]   step_cnt;
    logic            last_step;

    assign last_step = (step_cnt == CW'(DW - 1));

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            step_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (load_o)
                step_cnt <= '0;
            else if (step_o)
                step_cnt <= step_cnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i)   state_d = S_ITER;
            S_ITER: if (last_step) state_d = S_FIX;
            S_FIX:                 state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        busy_o = 1'b0;
        load_o = 1'b0;
        step_o = 1'b0;
        fix_o  = 1'b0;
        unique case (state_q)
            S_IDLE: load_o = start_i;
            S_ITER: begin busy_o = 1'b1; step_o = 1'b1; end
            S_FIX:  begin busy_o = 1'b1; fix_o  = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/lohi_div_core.sv
module lohi_div_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [DW-1:0] quo_o,
    output logic [DW-1:0] rem_o,
    output logic          neg_q_o,
    output logic          neg_r_o,
    output logic          zero_o,
    output logic [DW-1:0] dvd_o
);
    logic [DW-1:0] dvs_q;
    logic [DW:0]   shifted;
    logic [DW:0]   trial;
    logic          fits;

    function automatic logic [DW-1:0] mag(input logic [DW-1:0] v);
        return v[DW-1] ? (~v + 1'b1) : v;
    endfunction

    assign shifted = {rem_o, quo_o[DW-1]};
    assign trial   = shifted - {1'b0, dvs_q};
    assign fits    = ~trial[DW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_o   <= '0;
            rem_o   <= '0;
            dvs_q   <= '0;
            neg_q_o <= 1'b0;
            neg_r_o <= 1'b0;
            zero_o  <= 1'b0;
            dvd_o   <= '0;
        end else if (load_i) begin
            quo_o   <= mag(dividend_i);
            rem_o   <= '0;
            dvs_q   <= mag(divisor_i);
            neg_q_o <= dividend_i[DW-1] ^ divisor_i[DW-1];
            neg_r_o <= dividend_i[DW-1];
            zero_o  <= (divisor_i == '0);
            dvd_o   <= dividend_i;
        end else if (step_i) begin
            rem_o <= fits ? trial[DW-1:0] : shifted[DW-1:0];
            quo_o <= {quo_o[DW-2:0], fits};
        end
    end
endmodule

// File: rtl/lohi_div_fixup.sv
module lohi_div_fixup #(
    parameter int DW   = 32,
    parameter int XLEN = 64
) (
    input  logic [DW-1:0]   quo_i,
    input  logic [DW-1:0]   rem_i,
    input  logic            neg_q_i,
    input  logic            neg_r_i,
    input  logic            zero_i,
    input  logic [DW-1:0]   dvd_i,
    output logic [XLEN-1:0] lo_o,
    output logic [XLEN-1:0] hi_o
);
    localparam int EXT = XLEN - DW;

    logic [DW-1:0] q_s, r_s;

    assign q_s = neg_q_i ? (~quo_i + 1'b1) : quo_i;
    assign r_s = neg_r_i ? (~rem_i + 1'b1) : rem_i;

    always_comb begin
        if (zero_i) begin
            hi_o = {{EXT{dvd_i[DW-1]}}, dvd_i};
            lo_o = dvd_i[DW-1] ? XLEN'(1) : '1;
        end else begin
            lo_o = {{EXT{q_s[DW-1]}}, q_s};
            hi_o = {{EXT{r_s[DW-1]}}, r_s};
        end
    end
endmodule

// File: rtl/lohi_divider.sv
module lohi_divider #(
    parameter int XLEN = 64,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    output logic            done_o,
    output logic            busy_o,
    output logic [XLEN-1:0] lo_o,
    output logic [XLEN-1:0] hi_o
);
    logic          load, step, fix;
    logic [DW-1:0] quo, rem, dvd;
    logic          neg_q, neg_r, zero;
    logic [XLEN-1:0] lo_d, hi_d;
    logic          unused_upper;

    assign unused_upper = ^{op_a_i[XLEN-1:DW], op_b_i[XLEN-1:DW]};

    lohi_div_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .load_o(load), .step_o(step), .fix_o(fix)
    );

    lohi_div_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .dividend_i(op_a_i[DW-1:0]), .divisor_i(op_b_i[DW-1:0]),
        .quo_o(quo), .rem_o(rem), .neg_q_o(neg_q), .neg_r_o(neg_r),
        .zero_o(zero), .dvd_o(dvd)
    );

    lohi_div_fixup #(.DW(DW), .XLEN(XLEN)) u_fix (
        .quo_i(quo), .rem_i(rem), .neg_q_i(neg_q), .neg_r_i(neg_r),
        .zero_i(zero), .dvd_i(dvd), .lo_o(lo_d), .hi_o(hi_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            lo_o   <= '0;
            hi_o   <= '0;
        end else begin
            done_o <= fix;
            if (fix) begin
                lo_o <= lo_d;
                hi_o <= hi_d;
            end
        end
    end
endmodule

// File: rtl/lohi_divider_chk.sv
module lohi_divider_chk #(
    parameter int XLEN = 64,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [XLEN-1:0] op_a_i,
    input logic [XLEN-1:0] op_b_i,
    input logic            done_o,
    input logic            busy_o,
    input logic [XLEN-1:0] lo_o,
    input logic [XLEN-1:0] hi_o
);
    localparam int EXT = XLEN - DW;
    localparam int KW  = $clog2(DW + 2) + 1;

    logic [DW-1:0] lat_a, lat_b;
    logic [KW-1:0] since;
    logic          unused_chk;

    assign unused_chk = ^{op_a_i[XLEN-1:DW], op_b_i[XLEN-1:DW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a <= '0;
            lat_b <= '0;
            since <= '0;
        end else if (start_i && !busy_o) begin
            lat_a <= op_a_i[DW-1:0];
            lat_b <= op_b_i[DW-1:0];
            since <= '0;
        end else if (busy_o) begin
            since <= since + 1'b1;
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since == KW'(DW + 1)) && !busy_o);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(lo_o) && $stable(hi_o));
    assert_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lo_o[XLEN-1:DW] == {EXT{lo_o[DW-1]}}) &&
                   (hi_o[XLEN-1:DW] == {EXT{hi_o[DW-1]}}));
    assert_zero_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_b == '0) |-> hi_o == {{EXT{lat_a[DW-1]}}, lat_a});
    assert_zero_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_b == '0 && !lat_a[DW-1]) |-> &lo_o);
    assert_zero_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_b == '0 && lat_a[DW-1]) |-> lo_o == XLEN'(1));
    assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_b != '0 && hi_o != '0) |-> hi_o[DW-1] == lat_a[DW-1]);
endmodule

bind lohi_divider lohi_divider_chk #(.XLEN(XLEN), .DW(DW)) u_chk (.*);

// File: tb/lohi_divider_tb.sv
module lohi_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic        done_o, busy_o;
    logic [63:0] lo_o, hi_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lohi_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .done_o(done_o), .busy_o(busy_o), .lo_o(lo_o), .hi_o(hi_o)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] lo, output logic [63:0] hi);
        int sa, sb, q, r;
        sa = a[31:0];
        sb = b[31:0];
        if (sb == 0) begin
            hi = {{32{a[31]}}, a[31:0]};
            lo = (sa < 0) ? 64'd1 : '1;
        end else begin
            if (sa == 32'sh80000000 && sb == -1) begin
                q = sa; r = 0;
            end else begin
                q = sa / sb; r = sa % sb;
            end
            lo = {{32{q[31]}}, q};
            hi = {{32{r[31]}}, r};
        end
    endfunction

    // issue one division; optionally pulse a second start mid-way (R9)
    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input string tag, input bit poke = 1'b0);
        logic [63:0] el, eh;
        int n;
        model(a, b, el, eh);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; n = 1;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
            if (poke && n == 6) begin
                op_a_i = 64'd77; op_b_i = 64'd0; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        chk(n == 34, {tag, " R8 latency"}, 64'(n), 64'd34);
        chk(lo_o == el, {tag, " LO"}, lo_o, el);
        chk(hi_o == eh, {tag, " HI"}, hi_o, eh);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] a, b, kl, kh;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(!done_o && !busy_o && lo_o == 0 && hi_o == 0, "R10 reset state",
            {lo_o[62:0], done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run(64'hDEADBEEF_00000064, 64'h12345678_00000007, "R1 upper bits");
        run(64'd100, 64'd0, "R2 R3 pos/zero");
        run(64'd0, 64'hFFFFFFFF_00000000, "R3 zero/zero");
        run(64'hFFFFFFFF_FFFFFFFB, 64'd0, "R4 neg/zero");
        run(64'h00000000_FFFFFFFB, 64'hABCD0000_00000000, "R4 R1 neg/zero");
        run(-64'sd7, 64'd2, "R5 neg/pos");
        run(64'd7, -64'sd2, "R5 pos/neg");
        run(-64'sd7, -64'sd2, "R5 neg/neg");
        run(64'd6, 64'd3, "R5 exact");
        run(64'h00000000_80000000, 64'hFFFFFFFF_FFFFFFFF, "R7 min/-1");
        run(64'h00000000_80000000, 64'd1, "R6 min/1");
        run(64'd1, 64'h00000000_80000000, "R5 1/min");
        run(64'h7FFFFFFF, 64'd1, "R6 max/1");
        run(64'd1000, 64'd10, "R9 start while busy", 1'b1);

        // R9: no extra operation afterwards; R10: hold while idle
        kl = lo_o; kh = hi_o;
        begin
            bit extra;
            extra = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                op_a_i = $urandom; op_b_i = $urandom;
                if (done_o || busy_o) extra = 1'b1;
            end
            chk(!extra, "R9 no extra done", 64'(extra), 64'd0);
        end
        chk(lo_o == kl && hi_o == kh, "R10 hold LO/HI", lo_o, kl);

        for (int i = 0; i < 200; i++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 3 == 0) b[31:0] = 32'($urandom % 17) - 32'd8;
            if (i % 11 == 0) b[31:0] = '0;
            run(a, b, "R5 R6 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule